// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Divisor Baud Prescaler

This block is a full-duplex asynchronous serial transceiver that runs entirely from the system clock. A reloadable down-counter divides the system clock into an oversampling tick. A speed-select input sets how many ticks make one bit time: sixteen in normal mode and eight in double-speed mode. Both directions share one character format. The format has one start bit, five to eight data bits sent least significant first, an optional even or odd parity bit, and one or two stop bits.

On the transmit side, a one-byte holding register sits in front of the shift register. Software can therefore queue the next byte while the current one is still leaving the pin. On the receive side, each bit is sampled at its midpoint. The start bit is validated at its own midpoint. A completed character is placed in a receive buffer together with its framing, parity and overrun flags, and it stays there until it is read. One further complete character can wait behind the buffer.

Top module: `uart_xcvr`

## Requirements
- R1: The oversampling tick occurs once every `divisor`+1 system clocks. One bit time is 16 ticks when `dbl_speed`=0 and 8 ticks when `dbl_speed`=1.
- R2: `txd` idles at 1. A frame is a 0 start bit, then the data bits LSB first, then the parity bit when `par_en`=1, then the stop bits, which are 1 (two stop bits when `two_stop`=1). The number of data bits is 5 + `char_len` (`char_len` 0 to 3). With `par_odd`=0 the parity bit makes the count of ones in data plus parity even; with `par_odd`=1 it makes that count odd. The receiver uses the same settings.
- R3: A `tx_wr` pulse loads `tx_data` into the holding register and clears `tx_empty`. `tx_empty` returns to 1 when the byte moves into the shift register, and a second byte can then be written while the first is still shifting out. Both bytes are sent in order.
- R4: `tx_done` goes to 1 once the last stop bit has been sent and the holding register is empty. A `tx_wr` pulse clears it. It is 0 after reset.
- R5: A received character appears on `rx_data`, zero-extended to 8 bits, with `rx_ready`=1. It stays there until a `rx_rd` pulse.
- R6: A low level on `rxd` that has returned to 1 by the start bit's midpoint is treated as a glitch. No character is produced from it, and the next real frame is received correctly.
- R7: `err_frame` is set together with the character when the first stop bit is sampled as 0. It stays set until that character is read.
- R8: `err_parity` is set together with the character when parity is enabled and the received parity bit does not match R2. It stays set until that character is read.
- R9: Suppose the buffer is full, a further complete character is waiting behind it, and a new start bit arrives. Then the waiting character is discarded, `err_overrun` is set, and the buffered byte on `rx_data` is kept. Reading that byte clears `err_overrun`.
- R10: While `rx_en`=0 the receive buffer is flushed: `rx_ready`, `err_frame`, `err_parity` and `err_overrun` are all 0. They stay 0 after re-enabling until a new character arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| divisor | input | DIV_W | Prescaler reload value; tick period is divisor+1 clocks |
| dbl_speed | input | 1 | 1 selects 8 ticks per bit, 0 selects 16 |
| char_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| two_stop | input | 1 | Transmit two stop bits |
| tx_en | input | 1 | Allows the transmitter to start new frames |
| rx_en | input | 1 | Receiver enable; 0 flushes the receive buffer |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Read strobe that releases the receive buffer |
| rxd | input | 1 | Serial input line |
| txd | output | 1 | Serial output line |
| tx_empty | output | 1 | Transmit holding register can accept a byte |
| tx_done | output | 1 | Last frame fully sent, nothing pending |
| rx_data | output | 8 | Received character |
| rx_ready | output | 1 | Receive buffer holds an unread character |
| err_frame | output | 1 | Framing error of the buffered character |
| err_parity | output | 1 | Parity error of the buffered character |
| err_overrun | output | 1 | A waiting character was lost |

## Verification
A prescaler that miscounts shows up at once as a wrong frame length on `txd`. The bench measures that length to within one tick period in both speed modes. A wrong bit counter, shift direction or parity term in either state machine shows up as a mismatched byte or a spurious flag when the very next looped-back character is read. A receiver that loses its place after a glitch, or mishandles the buffer and the waiting slot, shows up as wrong `rx_data` or wrong flags after the following frame. This happens at the latest one frame after the fault.

// File: rtl/uart_pkg.sv
// Shared types and helpers for the serial transceiver.
// Assumes characters of 5..8 bits carried in an 8-bit container.
package uart_pkg;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP1, TX_STOP2
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAIT_HI
    } rx_state_t;

    // Mask keeping the low nbits of a byte
    function automatic logic [7:0] char_mask(input logic [3:0] nbits);
        return 8'hFF >> (4'd8 - nbits);
    endfunction

endpackage

// File: rtl/uart_baud.sv
// Baud prescaler: a down-counter reloaded with the divisor on reaching zero.
// Emits one tick per reload, i.e. every divisor+1 clocks.
// Assumes the divisor is held stable while traffic is in progress.
module uart_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt == '0);

    // Count down; reload on zero
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (tick)    cnt <= divisor;
        else              cnt <= cnt - 1'b1;
    end

    a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && divisor != '0) |=> !tick);

endmodule

// File: rtl/uart_tx.sv
// Transmitter: one-byte holding register feeding a shift register.
// A new frame starts when tx_en is high and the holding register is full.
// Assumes tick is a single-cycle strobe; os_last is ticks-per-bit minus one.
module uart_tx
    import uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [3:0] os_last,
    input  logic       tx_en,
    input  logic [3:0] len_bits,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       two_stop,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic       txd,
    output logic       empty,
    output logic       done
);
    tx_state_t  st;
    logic [7:0] hold;
    logic       hold_full;
    logic [7:0] sh;
    logic [2:0] bitn;
    logic [3:0] os;
    logic       par_bit;

    assign empty = !hold_full;

    // Frame sequencer, holding register and line driver
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= TX_IDLE; hold <= '0; hold_full <= 1'b0; sh <= '0;
            bitn <= '0; os <= '0; par_bit <= 1'b0; txd <= 1'b1; done <= 1'b0;
        end else begin
            if (st == TX_IDLE) begin
                if (tx_en && hold_full) begin
                    sh        <= hold;
                    par_bit   <= (^(hold & char_mask(len_bits))) ^ par_odd;
                    hold_full <= 1'b0;
                    st        <= TX_START;
                    os        <= '0;
                    txd       <= 1'b0;
                end
            end else if (tick) begin
                if (os != os_last) begin
                    os <= os + 1'b1;
                end else begin
                    os <= '0;
                    case (st)
                        TX_START: begin
                            st <= TX_DATA; bitn <= '0; txd <= sh[0];
                        end
                        TX_DATA: begin
                            if ({1'b0, bitn} == len_bits - 4'd1) begin
                                st  <= par_en ? TX_PAR : TX_STOP1;
                                txd <= par_en ? par_bit : 1'b1;
                            end else begin
                                sh   <= sh >> 1;
                                txd  <= sh[1];
                                bitn <= bitn + 1'b1;
                            end
                        end
                        TX_PAR: begin
                            st <= TX_STOP1; txd <= 1'b1;
                        end
                        TX_STOP1: begin
                            if (two_stop) st <= TX_STOP2;
                            else begin
                                st <= TX_IDLE;
                                if (!hold_full) done <= 1'b1;
                            end
                        end
                        default: begin
                            st <= TX_IDLE;
                            if (!hold_full) done <= 1'b1;
                        end
                    endcase
                end
            end
            if (wr) begin
                hold <= wdata; hold_full <= 1'b1; done <= 1'b0;
            end
        end
    end

    a_r2_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_IDLE) |-> txd);
    a_r3_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !empty);
    a_r4_done_implies_empty: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> empty);

endmodule

// File: rtl/uart_rx.sv
// Receiver: two-flop input synchroniser, mid-bit sampling, receive buffer
// with per-character error flags and one waiting slot behind the buffer.
// Assumes tick is a single-cycle strobe; os_mid is half a bit minus one tick.
module uart_rx
    import uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [3:0] os_last,
    input  logic [3:0] os_mid,
    input  logic       rx_en,
    input  logic [3:0] len_bits,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       rxd_in,
    input  logic       rd,
    output logic [7:0] rdata,
    output logic       ready,
    output logic       fe,
    output logic       pe,
    output logic       ovr
);
    rx_state_t  st;
    logic       s1, s2;
    logic [7:0] sh, wdat;
    logic [2:0] bitn;
    logic [3:0] os;
    logic       pacc, perr, waiting, wfe, wpe;
    logic       buf_free;
    logic [7:0] new_char;

    assign buf_free = !ready || (rd && !waiting);
    assign new_char = sh >> (4'd8 - len_bits);

    // Bring the asynchronous line into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin s1 <= 1'b1; s2 <= 1'b1; end
        else        begin s1 <= rxd_in; s2 <= s1; end
    end

    // Receive sequencer, buffer and flag bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) begin
            st <= RX_IDLE; sh <= '0; wdat <= '0; bitn <= '0; os <= '0;
            pacc <= 1'b0; perr <= 1'b0; waiting <= 1'b0; wfe <= 1'b0; wpe <= 1'b0;
            rdata <= '0; ready <= 1'b0; fe <= 1'b0; pe <= 1'b0; ovr <= 1'b0;
        end else begin
            if (rd && ready) begin
                if (waiting) begin
                    rdata <= wdat; fe <= wfe; pe <= wpe; ovr <= 1'b0; waiting <= 1'b0;
                end else begin
                    ready <= 1'b0; fe <= 1'b0; pe <= 1'b0; ovr <= 1'b0;
                end
            end
            case (st)
                RX_IDLE: begin
                    if (!s2) begin
                        st <= RX_START; os <= '0;
                        if (waiting && !rd) begin ovr <= 1'b1; waiting <= 1'b0; end
                    end
                end
                RX_START: if (tick) begin
                    if (os != os_mid) os <= os + 1'b1;
                    else if (s2)      st <= RX_IDLE;
                    else begin
                        st <= RX_DATA; os <= '0; bitn <= '0; pacc <= 1'b0;
                    end
                end
                RX_WAIT_HI: if (s2) st <= RX_IDLE;
                default: if (tick) begin
                    if (os != os_last) os <= os + 1'b1;
                    else begin
                        os <= '0;
                        if (st == RX_DATA) begin
                            sh   <= {s2, sh[7:1]};
                            pacc <= pacc ^ s2;
                            bitn <= bitn + 1'b1;
                            if ({1'b0, bitn} == len_bits - 4'd1)
                                st <= par_en ? RX_PAR : RX_STOP;
                        end else if (st == RX_PAR) begin
                            perr <= (s2 != (pacc ^ par_odd));
                            st   <= RX_STOP;
                        end else begin
                            st <= s2 ? RX_IDLE : RX_WAIT_HI;
                            if (buf_free) begin
                                rdata <= new_char; ready <= 1'b1; fe <= !s2;
                                pe <= par_en && perr; ovr <= 1'b0;
                            end else begin
                                wdat <= new_char; waiting <= 1'b1; wfe <= !s2;
                                wpe <= par_en && perr;
                            end
                        end
                    end
                end
            endcase
        end
    end

    a_r10_disable_flushes: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !ready);
    a_r7_flags_need_char: assert property (@(posedge clk) disable iff (!rst_n)
        (fe || pe || ovr) |-> ready);
    a_r9_overrun_keeps_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> (ready && $stable(rdata)));

endmodule

// File: rtl/uart_xcvr.sv
// Full-duplex asynchronous transceiver top: shared prescaler, transmitter
// and receiver. Assumes configuration inputs change only while idle.
module uart_xcvr #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic             dbl_speed,
    input  logic [1:0]       char_len,
    input  logic             par_en,
    input  logic             par_odd,
    input  logic             two_stop,
    input  logic             tx_en,
    input  logic             rx_en,
    input  logic             tx_wr,
    input  logic [7:0]       tx_data,
    input  logic             rx_rd,
    input  logic             rxd,
    output logic             txd,
    output logic             tx_empty,
    output logic             tx_done,
    output logic [7:0]       rx_data,
    output logic             rx_ready,
    output logic             err_frame,
    output logic             err_parity,
    output logic             err_overrun
);
    localparam logic [3:0] OS_LAST_N = 4'd15;
    localparam logic [3:0] OS_LAST_D = 4'd7;

    logic       tick;
    logic [3:0] os_last, os_mid, len_bits;

    assign os_last  = dbl_speed ? OS_LAST_D : OS_LAST_N;
    assign os_mid   = os_last >> 1;
    assign len_bits = 4'd5 + {2'b00, char_len};

    uart_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick)
    );

    uart_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .os_last(os_last), .tx_en(tx_en),
        .len_bits(len_bits), .par_en(par_en), .par_odd(par_odd),
        .two_stop(two_stop), .wr(tx_wr), .wdata(tx_data), .txd(txd),
        .empty(tx_empty), .done(tx_done)
    );

    uart_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .os_last(os_last), .os_mid(os_mid),
        .rx_en(rx_en), .len_bits(len_bits), .par_en(par_en), .par_odd(par_odd),
        .rxd_in(rxd), .rd(rx_rd), .rdata(rx_data), .ready(rx_ready),
        .fe(err_frame), .pe(err_parity), .ovr(err_overrun)
    );

endmodule

// File: tb/tb_uart_xcvr.sv
module tb_uart_xcvr;
    localparam int DIV = 3;

    logic       clk = 0, rst_n = 0;
    logic [15:0] divisor = 16'(DIV);
    logic       dbl_speed = 0, par_en = 0, par_odd = 0, two_stop = 0;
    logic [1:0] char_len = 2'd3;
    logic       tx_en = 1, rx_en = 1, tx_wr = 0, mon_rd = 0, man_rd = 0;
    logic [7:0] tx_data = '0;
    logic       loop = 1, line = 1;
    logic       rxd, txd, tx_empty, tx_done, rx_ready, err_frame, err_parity, err_overrun;
    logic [7:0] rx_data;
    logic       auto_rd = 1;

    int errs = 0, checks = 0;
    logic [7:0] exp_q[$];

    assign rxd = loop ? txd : line;

    uart_xcvr dut (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .dbl_speed(dbl_speed),
        .char_len(char_len), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
        .tx_en(tx_en), .rx_en(rx_en), .tx_wr(tx_wr), .tx_data(tx_data),
        .rx_rd(mon_rd | man_rd), .rxd(rxd), .txd(txd), .tx_empty(tx_empty),
        .tx_done(tx_done), .rx_data(rx_data), .rx_ready(rx_ready),
        .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int bit_time();
        return (dbl_speed ? 8 : 16) * (DIV + 1);
    endfunction

    task automatic set_cfg(input logic [1:0] cl, input bit pe, input bit po,
                           input bit ts, input bit ds);
        @(negedge clk);
        char_len = cl; par_en = pe; par_odd = po; two_stop = ts; dbl_speed = ds;
    endtask

    // Driver: write a byte and push what the receiver should deliver
    task automatic send_tx(input logic [7:0] b);
        @(negedge clk);
        tx_data = b; tx_wr = 1;
        exp_q.push_back(b & (8'hFF >> (3 - char_len)));
        @(negedge clk);
        tx_wr = 0;
    endtask

    // Scoreboard monitor: pop and compare each delivered loopback character
    always @(negedge clk) begin
        mon_rd <= 1'b0;
        if (auto_rd && rx_ready && !mon_rd) begin
            if (exp_q.size() == 0) chk(0, "R5 unexpected char", rx_data, 0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rx_data == e, "R5 loopback data", rx_data, e);
                chk(!err_frame && !err_parity && !err_overrun, "R2 clean flags",
                    {err_frame, err_parity, err_overrun}, 0);
            end
            mon_rd <= 1'b1;
        end
    end

    // Drive a frame on the receive line from the bench
    task automatic rx_frame(input logic [7:0] d, input int nb, input bit flip_par,
                            input bit stop_v);
        int bt;
        logic p;
        bt = bit_time();
        p = par_odd;
        line = 0; repeat (bt) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            line = d[i]; p ^= d[i]; repeat (bt) @(negedge clk);
        end
        if (par_en) begin line = p ^ flip_par; repeat (bt) @(negedge clk); end
        line = stop_v; repeat (bt) @(negedge clk);
        line = 1; repeat (bt) @(negedge clk);
    endtask

    task automatic pulse_rd();
        @(negedge clk); man_rd = 1; @(negedge clk); man_rd = 0;
    endtask

    task automatic frame_len(input int lo, input int hi, input string tag);
        int n;
        n = 0;
        send_tx(8'h00);
        while (txd) @(negedge clk);
        while (!txd) begin n++; @(negedge clk); end
        chk(n >= lo && n <= hi, tag, n, hi);
        wait (tx_done); repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(txd == 1, "R2 reset line idle", txd, 1);
        chk(tx_empty == 1 && tx_done == 0, "R4 reset tx flags", {tx_empty, tx_done}, 2);
        chk(rx_ready == 0, "R5 reset rx empty", rx_ready, 0);

        // R1: frame length of 0x00 8N1 is 9 bits low, both speeds
        frame_len(9*64 - DIV, 9*64, "R1 normal speed bit time");
        set_cfg(2'd3, 0, 0, 0, 1);
        frame_len(9*32 - DIV, 9*32, "R1 double speed bit time");

        // R2 loopback in several formats
        set_cfg(2'd3, 0, 0, 0, 0);
        send_tx(8'hA5); wait (tx_done);
        send_tx(8'h3C); wait (tx_done);
        set_cfg(2'd2, 1, 0, 1, 0);
        send_tx(8'h5B); wait (tx_done);
        set_cfg(2'd0, 1, 1, 0, 0);
        send_tx(8'hF7); wait (tx_done);
        set_cfg(2'd3, 1, 1, 1, 1);
        send_tx(8'hE1); wait (tx_done);
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all formats delivered", exp_q.size(), 0);

        // R3/R4: back-to-back via holding register
        set_cfg(2'd3, 0, 0, 0, 0);
        send_tx(8'h81);
        @(negedge clk);
        chk(tx_empty == 1 && txd == 0, "R3 holding passed to shifter", {tx_empty, txd}, 2);
        chk(tx_done == 0, "R4 not done while shifting", tx_done, 0);
        send_tx(8'h7E);
        chk(tx_empty == 0, "R3 second byte held", tx_empty, 0);
        wait (tx_done);
        chk(txd == 1 && tx_empty == 1, "R4 done after last stop", {txd, tx_empty}, 3);
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R3 both bytes delivered", exp_q.size(), 0);

        // Bench-driven receive tests
        loop = 0; auto_rd = 0;
        rx_frame(8'h5A, 8, 0, 0);
        chk(rx_ready && rx_data == 8'h5A, "R7 data kept with framing error", rx_data, 8'h5A);
        chk(err_frame == 1 && err_parity == 0, "R7 framing flag", {err_frame, err_parity}, 2);
        pulse_rd();
        chk(!rx_ready && !err_frame, "R7 flag cleared by read", {rx_ready, err_frame}, 0);

        set_cfg(2'd3, 1, 0, 0, 0);
        rx_frame(8'h33, 8, 1, 1);
        chk(rx_data == 8'h33 && err_parity == 1, "R8 even parity error", {err_parity, rx_data}, 9'h133);
        pulse_rd();
        set_cfg(2'd2, 1, 1, 0, 0);
        rx_frame(8'h41, 7, 0, 1);
        chk(rx_data == 8'h41 && err_parity == 0, "R8 odd parity good", {err_parity, rx_data}, 9'h041);
        pulse_rd();

        set_cfg(2'd3, 0, 0, 0, 0);
        line = 0; repeat (16) @(negedge clk); line = 1;
        repeat (128) @(negedge clk);
        chk(rx_ready == 0, "R6 glitch rejected", rx_ready, 0);
        rx_frame(8'hC3, 8, 0, 1);
        chk(rx_ready && rx_data == 8'hC3, "R6 next frame intact", rx_data, 8'hC3);
        pulse_rd();

        rx_frame(8'h11, 8, 0, 1);
        rx_frame(8'h22, 8, 0, 1);
        chk(rx_data == 8'h11 && !err_overrun, "R9 first byte buffered", {err_overrun, rx_data}, 9'h011);
        rx_frame(8'h33, 8, 0, 1);
        chk(rx_data == 8'h11 && err_overrun, "R9 overrun flagged, byte kept", {err_overrun, rx_data}, 9'h111);
        pulse_rd();
        chk(rx_ready && rx_data == 8'h33 && !err_overrun, "R9 after read", {err_overrun, rx_data}, 9'h033);
        pulse_rd();
        chk(!rx_ready, "R5 buffer released by read", rx_ready, 0);

        rx_frame(8'h77, 8, 0, 0);
        chk(rx_ready && err_frame, "R10 setup char present", {rx_ready, err_frame}, 3);
        @(negedge clk); rx_en = 0;
        repeat (2) @(negedge clk);
        chk(!rx_ready && !err_frame && !err_parity && !err_overrun, "R10 disable flushes",
            {rx_ready, err_frame, err_parity, err_overrun}, 0);
        rx_en = 1;
        repeat (4) @(negedge clk);
        chk(!rx_ready && !err_frame, "R10 stays empty after enable", {rx_ready, err_frame}, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule